// File: doc/BRIEF.md
# Spatial Region Footprint Prefetcher

The block watches a stream of cache accesses and splits the address space into fixed-size regions of a few cache lines each. For every region it records which lines get touched between the first access and the moment one of the region's blocks leaves the cache (an end event for eviction or invalidation). That record, a bit vector with one bit per line, is kept under a signature formed from the PC of the instruction that opened the region and the line offset of that first access.

A region is first held in a small filter table while only one line has been seen. When a second, different line arrives, it moves to an accumulation table, which collects further line bits. At the end event an accumulated footprint is written into a direct-mapped pattern table. Later, when a fresh region is opened by an access whose signature is found there, the block issues prefetch addresses for every recorded line of that new region except the one just accessed, lowest offset first, one per cycle.

When a tracking table is full, a round-robin victim is overwritten and its generation is discarded without being stored. A new pattern-table hit replaces any replay still in progress.

Top module: `footprint_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0 and every table is empty, so no access triggers a prefetch until a footprint has been stored.
- R2: An address splits into byte-in-line bits [LINE_W-1:0], line offset bits [LINE_W+OFF_W-1:LINE_W] and the region tag above them. Footprint bit i stands for line offset i. A prefetch address is the region tag and line offset with the byte bits zero; with defaults, region base + 64*i.
- R3: An access to a region held in neither tracking table opens a filter entry whose signature is {pc, line offset}. Nothing is stored in the pattern table at that point.
- R4: A second access to a different line of a filtered region moves it to accumulation with both line bits set. Later accesses set more bits. An access to a line already recorded, in either table, changes nothing.
- R5: An end event whose line address falls in an accumulating region writes its footprint into the pattern table under the region's signature, replacing any earlier footprint for that signature. The entry index is the low 4 signature bits, {pc[1:0], offset}, and the full signature is kept as tag.
- R6: An end event for a region still in the filter table drops it and leaves the pattern table unchanged. An end event for an untracked region has no effect.
- R7: An access that opens a new region with a stored signature issues one prefetch per set footprint bit other than the accessed line, in ascending offset order, on consecutive cycles. The first `pf_valid` appears after the second rising edge counted from the edge that samples the access.
- R8: An access that opens a new region whose {pc, offset} signature has no stored footprint issues no prefetch, even if the same PC is stored with another offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access observed this cycle |
| acc_pc | input | PC_W | PC of the accessing instruction |
| acc_addr | input | ADDR_W | Byte address of the access |
| end_valid | input | 1 | A block left the cache this cycle |
| end_addr | input | ADDR_W | Address of the block that left |
| pf_valid | output | 1 | Prefetch address valid (registered) |
| pf_addr | output | ADDR_W | Line-aligned prefetch address (registered) |

## Verification
The checks take for granted that an access and an end event never arrive in the same cycle. If they do, the end event wins and the access is lost, and the bench keeps the two apart by driving at most one event per cycle. They also take table depths to be powers of two and assume that no replay is cut short by a new trigger inside the window being checked. The bench lets each replay drain for several idle cycles before the next trigger. Every scenario uses its own region tags, so the filter and accumulation tables never fill, and each triggered region is ended afterwards.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
package fp_pkg;
  localparam int DEF_ADDR_W       = 32;
  localparam int DEF_PC_W         = 16;
  localparam int DEF_LINE_W       = 6;
  localparam int DEF_REGION_LINES = 4;
  localparam int DEF_FT_DEPTH     = 8;
  localparam int DEF_AT_DEPTH     = 8;
  localparam int DEF_PHT_DEPTH    = 16;
endpackage

// File: rtl/fp_gen_track.sv
`timescale 1ns/1ps
module fp_gen_track #(
  parameter int ADDR_W       = fp_pkg::DEF_ADDR_W,
  parameter int PC_W         = fp_pkg::DEF_PC_W,
  parameter int LINE_W       = fp_pkg::DEF_LINE_W,
  parameter int REGION_LINES = fp_pkg::DEF_REGION_LINES,
  parameter int FT_DEPTH     = fp_pkg::DEF_FT_DEPTH,
  parameter int AT_DEPTH     = fp_pkg::DEF_AT_DEPTH,
  localparam int OFF_W = $clog2(REGION_LINES),
  localparam int TAG_W = ADDR_W - LINE_W - OFF_W,
  localparam int SIG_W = PC_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic [PC_W-1:0]         acc_pc,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic                    end_valid,
  input  logic [ADDR_W-1:0]       end_addr,
  output logic                    trig_valid,
  output logic [SIG_W-1:0]        trig_sig,
  output logic [TAG_W-1:0]        trig_tag,
  output logic [OFF_W-1:0]        trig_off,
  output logic                    commit_valid,
  output logic [SIG_W-1:0]        commit_sig,
  output logic [REGION_LINES-1:0] commit_vec
);
  localparam int FT_IW = $clog2(FT_DEPTH);
  localparam int AT_IW = $clog2(AT_DEPTH);

  logic [TAG_W-1:0]        a_tag, e_tag;
  logic [OFF_W-1:0]        a_off;
  logic [REGION_LINES-1:0] a_bit;
  logic                    unused_bytes;

  assign a_tag = acc_addr[ADDR_W-1 -: TAG_W];
  assign a_off = acc_addr[LINE_W +: OFF_W];
  assign e_tag = end_addr[ADDR_W-1 -: TAG_W];
  assign a_bit = REGION_LINES'(1) << a_off;
  assign unused_bytes = ^{acc_addr[LINE_W-1:0], end_addr[LINE_W+OFF_W-1:0]};

  // filter table: one line seen so far
  logic [FT_DEPTH-1:0] ft_v;
  logic [TAG_W-1:0]    ft_tag [FT_DEPTH];
  logic [SIG_W-1:0]    ft_sig [FT_DEPTH];
  // accumulation table: two or more lines seen
  logic [AT_DEPTH-1:0]     at_v;
  logic [TAG_W-1:0]        at_tag [AT_DEPTH];
  logic [SIG_W-1:0]        at_sig [AT_DEPTH];
  logic [REGION_LINES-1:0] at_vec [AT_DEPTH];

  logic [FT_DEPTH-1:0] ft_ahit, ft_ehit;
  logic [AT_DEPTH-1:0] at_ahit, at_ehit;

  for (genvar i = 0; i < FT_DEPTH; i++) begin : g_ft_cmp
    assign ft_ahit[i] = ft_v[i] && (ft_tag[i] == a_tag);
    assign ft_ehit[i] = ft_v[i] && (ft_tag[i] == e_tag);
  end
  for (genvar j = 0; j < AT_DEPTH; j++) begin : g_at_cmp
    assign at_ahit[j] = at_v[j] && (at_tag[j] == a_tag);
    assign at_ehit[j] = at_v[j] && (at_tag[j] == e_tag);
  end

  logic [FT_IW-1:0] ft_aidx, ft_eidx, ft_slot, ft_rr;
  logic [AT_IW-1:0] at_aidx, at_eidx, at_slot, at_rr;
  logic             ft_has_free, at_has_free;

  always_comb begin
    ft_aidx = '0; ft_eidx = '0; ft_slot = ft_rr; ft_has_free = 1'b0;
    for (int i = FT_DEPTH - 1; i >= 0; i--) begin
      if (ft_ahit[i]) ft_aidx = FT_IW'(i);
      if (ft_ehit[i]) ft_eidx = FT_IW'(i);
      if (!ft_v[i]) begin
        ft_slot = FT_IW'(i);
        ft_has_free = 1'b1;
      end
    end
    if (!ft_has_free) ft_slot = ft_rr;
  end

  always_comb begin
    at_aidx = '0; at_eidx = '0; at_slot = at_rr; at_has_free = 1'b0;
    for (int j = AT_DEPTH - 1; j >= 0; j--) begin
      if (at_ahit[j]) at_aidx = AT_IW'(j);
      if (at_ehit[j]) at_eidx = AT_IW'(j);
      if (!at_v[j]) begin
        at_slot = AT_IW'(j);
        at_has_free = 1'b1;
      end
    end
    if (!at_has_free) at_slot = at_rr;
  end

  logic [OFF_W-1:0] ft_first_off;
  assign ft_first_off = ft_sig[ft_aidx][OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_v  <= '0;
      at_v  <= '0;
      ft_rr <= '0;
      at_rr <= '0;
    end else if (end_valid) begin
      if (|at_ehit) at_v[at_eidx] <= 1'b0;
      if (|ft_ehit) ft_v[ft_eidx] <= 1'b0;
    end else if (acc_valid) begin
      if (|at_ahit) begin
        at_vec[at_aidx] <= at_vec[at_aidx] | a_bit;
      end else if (|ft_ahit) begin
        if (ft_first_off != a_off) begin
          ft_v[ft_aidx]   <= 1'b0;
          at_v[at_slot]   <= 1'b1;
          at_tag[at_slot] <= a_tag;
          at_sig[at_slot] <= ft_sig[ft_aidx];
          at_vec[at_slot] <= a_bit | (REGION_LINES'(1) << ft_first_off);
          if (!at_has_free) at_rr <= at_rr + 1'b1;
        end
      end else begin
        ft_v[ft_slot]   <= 1'b1;
        ft_tag[ft_slot] <= a_tag;
        ft_sig[ft_slot] <= {acc_pc, a_off};
        if (!ft_has_free) ft_rr <= ft_rr + 1'b1;
      end
    end
  end

  assign trig_valid   = acc_valid && !end_valid && !(|ft_ahit) && !(|at_ahit);
  assign trig_sig     = {acc_pc, a_off};
  assign trig_tag     = a_tag;
  assign trig_off     = a_off;
  assign commit_valid = end_valid && (|at_ehit);
  assign commit_sig   = at_sig[at_eidx];
  assign commit_vec   = at_vec[at_eidx];
endmodule

// File: rtl/fp_pattern_mem.sv
`timescale 1ns/1ps
module fp_pattern_mem #(
  parameter int SIG_W = 18,
  parameter int VEC_W = 4,
  parameter int DEPTH = fp_pkg::DEF_PHT_DEPTH,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAGW  = SIG_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SIG_W-1:0] wr_sig,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic             rd_en,
  input  logic [SIG_W-1:0] rd_sig,
  output logic             hit,
  output logic [VEC_W-1:0] vec
);
  logic [TAGW+VEC_W-1:0] mem [DEPTH];
  logic [TAGW+VEC_W-1:0] rd_q;
  logic [DEPTH-1:0]      vbits;
  logic                  rd_v_q;
  logic [TAGW-1:0]       req_tag_q;

  // plain synchronous RAM, no reset, suitable for block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_sig[IDX_W-1:0]] <= {wr_sig[SIG_W-1:IDX_W], wr_vec};
    rd_q <= mem[rd_sig[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits     <= '0;
      rd_v_q    <= 1'b0;
      req_tag_q <= '0;
    end else begin
      if (wr_en) vbits[wr_sig[IDX_W-1:0]] <= 1'b1;
      rd_v_q    <= rd_en && vbits[rd_sig[IDX_W-1:0]];
      req_tag_q <= rd_sig[SIG_W-1:IDX_W];
    end
  end

  assign hit = rd_v_q && (rd_q[TAGW+VEC_W-1:VEC_W] == req_tag_q);
  assign vec = rd_q[VEC_W-1:0];
endmodule

// File: rtl/fp_replay.sv
`timescale 1ns/1ps
module fp_replay #(
  parameter int ADDR_W = fp_pkg::DEF_ADDR_W,
  parameter int LINE_W = fp_pkg::DEF_LINE_W,
  parameter int VEC_W  = fp_pkg::DEF_REGION_LINES,
  localparam int OFF_W = $clog2(VEC_W),
  localparam int TAG_W = ADDR_W - LINE_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_v,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [VEC_W-1:0]  ld_vec,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  logic [VEC_W-1:0] mask, m_now;
  logic [TAG_W-1:0] cur_tag, t_now;
  logic [OFF_W-1:0] pick;
  logic             found;

  always_comb begin
    m_now = ld_v ? (ld_vec & ~(VEC_W'(1) << ld_off)) : mask;
    t_now = ld_v ? ld_tag : cur_tag;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < VEC_W; i++) begin
      if (!found && m_now[i]) begin
        pick  = OFF_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '0;
      cur_tag  <= '0;
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      cur_tag  <= t_now;
      pf_valid <= found;
      if (found) begin
        pf_addr <= {t_now, pick, {LINE_W{1'b0}}};
        mask    <= m_now & ~(VEC_W'(1) << pick);
      end else begin
        mask <= '0;
      end
    end
  end
endmodule

// File: rtl/footprint_prefetcher.sv
`timescale 1ns/1ps
module footprint_prefetcher #(
  parameter int ADDR_W       = fp_pkg::DEF_ADDR_W,
  parameter int PC_W         = fp_pkg::DEF_PC_W,
  parameter int LINE_W       = fp_pkg::DEF_LINE_W,
  parameter int REGION_LINES = fp_pkg::DEF_REGION_LINES,
  parameter int FT_DEPTH     = fp_pkg::DEF_FT_DEPTH,
  parameter int AT_DEPTH     = fp_pkg::DEF_AT_DEPTH,
  parameter int PHT_DEPTH    = fp_pkg::DEF_PHT_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              end_valid,
  input  logic [ADDR_W-1:0] end_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int OFF_W = $clog2(REGION_LINES);
  localparam int TAG_W = ADDR_W - LINE_W - OFF_W;
  localparam int SIG_W = PC_W + OFF_W;

  logic                    trig_valid, commit_valid, pat_hit;
  logic [SIG_W-1:0]        trig_sig, commit_sig;
  logic [TAG_W-1:0]        trig_tag, ctx_tag;
  logic [OFF_W-1:0]        trig_off, ctx_off;
  logic [REGION_LINES-1:0] commit_vec, pat_vec;
  logic                    ctx_v;

  fp_gen_track #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .LINE_W(LINE_W),
    .REGION_LINES(REGION_LINES), .FT_DEPTH(FT_DEPTH), .AT_DEPTH(AT_DEPTH)
  ) u_track (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .end_valid(end_valid), .end_addr(end_addr),
    .trig_valid(trig_valid), .trig_sig(trig_sig),
    .trig_tag(trig_tag), .trig_off(trig_off),
    .commit_valid(commit_valid), .commit_sig(commit_sig), .commit_vec(commit_vec)
  );

  fp_pattern_mem #(
    .SIG_W(SIG_W), .VEC_W(REGION_LINES), .DEPTH(PHT_DEPTH)
  ) u_pht (
    .clk(clk), .rst(rst),
    .wr_en(commit_valid), .wr_sig(commit_sig), .wr_vec(commit_vec),
    .rd_en(trig_valid), .rd_sig(trig_sig),
    .hit(pat_hit), .vec(pat_vec)
  );

  // lookup context, aligned with the registered pattern read
  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_v   <= 1'b0;
      ctx_tag <= '0;
      ctx_off <= '0;
    end else begin
      ctx_v   <= trig_valid;
      ctx_tag <= trig_tag;
      ctx_off <= trig_off;
    end
  end

  fp_replay #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .VEC_W(REGION_LINES)
  ) u_replay (
    .clk(clk), .rst(rst),
    .ld_v(ctx_v && pat_hit), .ld_tag(ctx_tag), .ld_off(ctx_off), .ld_vec(pat_vec),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );
endmodule

// File: rtl/footprint_prefetcher_chk.sv
`timescale 1ns/1ps
module footprint_prefetcher_chk #(
  parameter int ADDR_W       = 32,
  parameter int LINE_W       = 6,
  parameter int REGION_LINES = 4,
  localparam int OFF_W = $clog2(REGION_LINES),
  localparam int TAG_W = ADDR_W - LINE_W - OFF_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    commit_valid,
  input logic [REGION_LINES-1:0] commit_vec,
  input logic                    ctx_v,
  input logic [TAG_W-1:0]        ctx_tag,
  input logic [OFF_W-1:0]        ctx_off,
  input logic                    pat_hit,
  input logic [REGION_LINES-1:0] pat_vec,
  input logic                    pf_valid,
  input logic [ADDR_W-1:0]       pf_addr
);
  // R6: single-line generations are never stored
  assert_multi_line_commit_R6: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> ($countones(commit_vec) >= 2));

  // R7: a hit with other lines recorded starts a replay in the new region
  assert_hit_starts_replay_R7: assert property (@(posedge clk) disable iff (rst)
    (ctx_v && pat_hit && ((pat_vec & ~(REGION_LINES'(1) << ctx_off)) != '0))
    |=> (pf_valid && (pf_addr[ADDR_W-1 -: TAG_W] == $past(ctx_tag))));

  // R7: an uninterrupted replay stays in one region and climbs in offset
  assert_ascending_replay_R7: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && $past(pf_valid) && !$past(ctx_v)) |->
    ((pf_addr[ADDR_W-1 -: TAG_W] == $past(pf_addr[ADDR_W-1 -: TAG_W])) &&
     (pf_addr[LINE_W +: OFF_W] > $past(pf_addr[LINE_W +: OFF_W]))));

  // R1: a prefetch only ever follows a pattern lookup or an earlier prefetch
  assert_pf_has_cause_R1: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> ($past(pf_valid) || $past(ctx_v)));
endmodule

bind footprint_prefetcher footprint_prefetcher_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .REGION_LINES(REGION_LINES)
) u_chk (
  .clk(clk), .rst(rst),
  .commit_valid(commit_valid), .commit_vec(commit_vec),
  .ctx_v(ctx_v), .ctx_tag(ctx_tag), .ctx_off(ctx_off),
  .pat_hit(pat_hit), .pat_vec(pat_vec),
  .pf_valid(pf_valid), .pf_addr(pf_addr)
);

// File: tb/footprint_prefetcher_tb.sv
`timescale 1ns/1ps
module footprint_prefetcher_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        end_valid = 1'b0;
  logic [31:0] end_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          pf_n = 0;
  logic [31:0] pf_a [16];
  int          pf_t [16];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  footprint_prefetcher u_dut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_pc(acc_pc), .acc_addr(acc_addr),
    .end_valid(end_valid), .end_addr(end_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  always @(negedge clk) begin
    if (!rst && pf_valid && pf_n < 16) begin
      pf_a[pf_n] = pf_addr;
      pf_t[pf_n] = cyc;
      pf_n = pf_n + 1;
    end
  end

  function automatic logic [31:0] la(input logic [23:0] rtag, input logic [1:0] off);
    return {rtag, off, 6'b0};
  endfunction

  task automatic check(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] pc, input logic [23:0] rtag, input logic [1:0] off);
    @(negedge clk);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = la(rtag, off) | 32'h5;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic end_ev(input logic [23:0] rtag, input logic [1:0] off);
    @(negedge clk);
    end_valid = 1'b1; end_addr = la(rtag, off);
    @(negedge clk);
    end_valid = 1'b0;
  endtask

  // opens a region, returns the cycle stamp of the driving negedge
  task automatic trigger(input logic [15:0] pc, input logic [23:0] rtag, input logic [1:0] off, output int t0);
    @(negedge clk);
    pf_n = 0;
    acc_valid = 1'b1; acc_pc = pc; acc_addr = la(rtag, off);
    t0 = cyc;
    @(negedge clk);
    acc_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    int t0;
    check("R1 pf_valid low after reset", pf_valid == 1'b0, 32'(pf_valid), 0);
    trigger(16'h0777, 24'h000050, 2'd3, t0);
    check("R1 no prefetch from empty tables", pf_n == 0, pf_n, 0);
    end_ev(24'h000050, 2'd3);
  endtask

  task automatic t_train_replay;
    int t0;
    access(16'h1234, 24'h000100, 2'd1);
    access(16'h1234, 24'h000100, 2'd3);
    access(16'h1234, 24'h000100, 2'd2);
    end_ev(24'h000100, 2'd0);
    trigger(16'h1234, 24'h000101, 2'd1, t0);
    check("R7 replay count", pf_n == 2, pf_n, 2);
    check("R2 R7 first prefetch offset 2", pf_a[0] == la(24'h000101, 2'd2), pf_a[0], la(24'h000101, 2'd2));
    check("R4 R7 second prefetch offset 3", pf_a[1] == la(24'h000101, 2'd3), pf_a[1], la(24'h000101, 2'd3));
    check("R7 first prefetch timing", pf_t[0] == t0 + 2, pf_t[0], t0 + 2);
    check("R7 back-to-back issue", pf_t[1] == pf_t[0] + 1, pf_t[1], pf_t[0] + 1);
    end_ev(24'h000101, 2'd1);
  endtask

  task automatic t_sig_mismatch;
    int t0;
    trigger(16'h1234, 24'h000102, 2'd0, t0);
    check("R3 R8 other offset is another signature", pf_n == 0, pf_n, 0);
    end_ev(24'h000102, 2'd0);
    trigger(16'h1230, 24'h000103, 2'd1, t0);
    check("R8 other pc is another signature", pf_n == 0, pf_n, 0);
    end_ev(24'h000103, 2'd1);
  endtask

  task automatic t_drop_single;
    int t0;
    access(16'h0042, 24'h000200, 2'd2);
    access(16'h0042, 24'h000200, 2'd0);
    end_ev(24'h000200, 2'd1);
    access(16'h0042, 24'h000201, 2'd2);
    end_ev(24'h000201, 2'd2);
    end_ev(24'h000999, 2'd0);
    trigger(16'h0042, 24'h000202, 2'd2, t0);
    check("R6 dropped generation kept old footprint", pf_n == 1, pf_n, 1);
    check("R6 replayed offset 0", pf_a[0] == la(24'h000202, 2'd0), pf_a[0], la(24'h000202, 2'd0));
    end_ev(24'h000202, 2'd2);
  endtask

  task automatic t_repeat_line;
    int t0;
    access(16'h0100, 24'h000300, 2'd0);
    access(16'h0100, 24'h000300, 2'd0);
    access(16'h0100, 24'h000300, 2'd1);
    access(16'h0100, 24'h000300, 2'd1);
    end_ev(24'h000300, 2'd1);
    trigger(16'h0100, 24'h000301, 2'd0, t0);
    check("R4 repeats add no lines", pf_n == 1, pf_n, 1);
    check("R4 only offset 1 replayed", pf_a[0] == la(24'h000301, 2'd1), pf_a[0], la(24'h000301, 2'd1));
    end_ev(24'h000301, 2'd0);
  endtask

  task automatic t_full_order;
    int t0;
    access(16'h0777, 24'h000400, 2'd3);
    access(16'h0777, 24'h000400, 2'd0);
    access(16'h0777, 24'h000400, 2'd1);
    access(16'h0777, 24'h000400, 2'd2);
    end_ev(24'h000400, 2'd2);
    trigger(16'h0777, 24'h000401, 2'd3, t0);
    check("R7 three prefetches", pf_n == 3, pf_n, 3);
    for (int k = 0; k < 3; k++) begin
      check("R2 R7 ascending address", pf_a[k] == la(24'h000401, 2'(k)), pf_a[k], la(24'h000401, 2'(k)));
    end
    check("R7 one per cycle", pf_t[2] == pf_t[0] + 2, pf_t[2], pf_t[0] + 2);
    end_ev(24'h000401, 2'd3);
  endtask

  task automatic t_retrain;
    int t0;
    access(16'h1234, 24'h000500, 2'd1);
    access(16'h1234, 24'h000500, 2'd3);
    end_ev(24'h000500, 2'd3);
    trigger(16'h1234, 24'h000501, 2'd1, t0);
    check("R5 new footprint replaces old", pf_n == 1, pf_n, 1);
    check("R5 replayed offset 3", pf_a[0] == la(24'h000501, 2'd3), pf_a[0], la(24'h000501, 2'd3));
    end_ev(24'h000501, 2'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_train_replay();
    t_sig_mismatch();
    t_drop_single();
    t_repeat_line();
    t_full_order();
    t_retrain();
    finish_run();
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule